// File: doc/BRIEF.md
# T1 Receive Alarm Responder

This controller sits beside the receive framer of a T1/J1 line interface and reacts without software help to the receiver's status. When frame alignment is lost it can ask the transmitter to send a remote (yellow) alarm toward the far end. It withdraws that request once the receiver is synchronous again.

While the receiver is out of sync it replaces the receive data going to the system with all ones (AIS). A transparency control lets the received data pass through unchanged instead. The block also picks the clock source. In slave mode it tracks the recovered line clock. On loss of signal it falls back to free-running master, and it returns to slave only after the signal has been present for a programmable number of frames.

A freeze flag holds received signaling while alignment or signal is missing. The flag releases at the first frame boundary after sync has come back.

The framer drives `frm_tick_i` for one cycle at each frame boundary. All status inputs are sampled on `clk_i`, the receive-side clock. Every output is a register, so every reaction shows up one clock after the input that causes it.

Top module: `t1_alarm_resp`

## Requirements
- R1: With `rai_auto_en_i` high, a high `lfa_i` makes `rai_req_o` high one clock later.
- R2: `rai_req_o` stays high while the receiver is not synchronous. It goes low one clock after a cycle with `sync_i` high and `lfa_i` low, or after any cycle with `rai_auto_en_i` low. It never rises while the enable is low.
- R3: With `ais_transp_i` low, a cycle with `sync_i` low gives `ais_active_o` high and every bit of `rx_sys_data_o` at 1 one clock later.
- R4: With `ais_transp_i` high, `ais_active_o` is low and `rx_sys_data_o` equals `rx_data_i` delayed by one clock, whatever the sync state. The same pass-through holds when `sync_i` is high.
- R5: With `slave_mode_i` high (1 = slave), a high `los_i` drives `clk_sel_o` to 0 (free-running master) one clock later. `clk_sel_o` = 1 selects the recovered clock.
- R6: After loss of signal (and after reset), `clk_sel_o` returns to 1 only after `los_hold_i` frame ticks have been seen with `los_i` low. It rises one clock after the cycle in which that count is reached. A high `los_i` restarts the count. With `los_hold_i` = 0 it rises one clock after the first cycle with `los_i` low.
- R7: With `slave_mode_i` low, `clk_sel_o` is 0.
- R8: With `freeze_dis_i` low, a high `lfa_i` or `los_i` makes `freeze_o` high one clock later.
- R9: Once frozen, `freeze_o` stays high while `sync_i` is low. It falls one clock after the first frame tick that follows a cycle with `sync_i` high and neither `lfa_i` nor `los_i` set.
- R10: With `freeze_dis_i` high, `freeze_o` is low one clock later and stays low.
- R11: During reset, `rai_req_o`, `ais_active_o`, `rx_sys_data_o`, `clk_sel_o` and `freeze_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive-side clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frm_tick_i | input | 1 | One-cycle pulse per received frame |
| lfa_i | input | 1 | Frame alignment lost |
| sync_i | input | 1 | Receiver synchronous |
| los_i | input | 1 | Loss of signal |
| rai_auto_en_i | input | 1 | Enable automatic remote alarm |
| ais_transp_i | input | 1 | Pass receive data through instead of AIS |
| slave_mode_i | input | 1 | 1 = track recovered clock, 0 = master |
| freeze_dis_i | input | 1 | Disable automatic signaling freeze |
| los_hold_i | input | HOLD_W | Frames of present signal before returning to slave |
| rx_data_i | input | DW | Received data lanes |
| rai_req_o | output | 1 | Remote alarm request to transmitter |
| ais_active_o | output | 1 | AIS override in force |
| rx_sys_data_o | output | DW | Receive data toward the system |
| clk_sel_o | output | 1 | 1 = recovered clock, 0 = free-running |
| freeze_o | output | 1 | Hold received signaling |

## Verification
The bench builds the block with DW = 4 and HOLD_W = 3. The four-bit lane makes the all-ones override distinguishable from single data patterns. The three-bit hold makes both the shortest return (0 frames) and a multi-frame return (3 frames, interrupted once by loss of signal) reachable in a few dozen cycles. Freeze release is exercised with the frame tick arriving in the same cycle that sync returns, so the release has to wait for a later tick.

// File: rtl/t1ar_pkg.sv
package t1ar_pkg;

    typedef enum logic {
        CS_FREE  = 1'b0,
        CS_TRACK = 1'b1
    } clk_state_e;

    typedef enum logic [1:0] {
        FZ_IDLE  = 2'd0,
        FZ_HOLD  = 2'd1,
        FZ_ARMED = 2'd2
    } frz_state_e;

endpackage

// File: rtl/t1ar_rai_ctl.sv
module t1ar_rai_ctl (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lfa_i,
    input  logic sync_i,
    input  logic en_i,
    output logic rai_o
);

    typedef struct packed {
        logic rai;
    } rai_regs_t;

    rai_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!en_i) begin
            r_d.rai = 1'b0;
        end else if (lfa_i) begin
            r_d.rai = 1'b1;
        end else if (sync_i) begin
            r_d.rai = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rai_o = r_q.rai;

endmodule

// File: rtl/t1ar_ais_path.sv
module t1ar_ais_path #(
    parameter int DW = 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          sync_i,
    input  logic          transp_i,
    input  logic [DW-1:0] data_i,
    output logic          ais_o,
    output logic [DW-1:0] data_o
);

    typedef struct packed {
        logic          ais;
        logic [DW-1:0] data;
    } ais_regs_t;

    ais_regs_t     r_d, r_q;
    logic          force_ones;
    logic [DW-1:0] lane_next;

    assign force_ones = !sync_i && !transp_i;

    for (genvar g = 0; g < DW; g++) begin : g_lane
        assign lane_next[g] = force_ones ? 1'b1 : data_i[g];
    end

    always_comb begin
        r_d      = r_q;
        r_d.ais  = force_ones;
        r_d.data = lane_next;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ais_o  = r_q.ais;
    assign data_o = r_q.data;

endmodule

// File: rtl/t1ar_clk_fallback.sv
module t1ar_clk_fallback
    import t1ar_pkg::*;
#(
    parameter int HOLD_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              los_i,
    input  logic              slave_i,
    input  logic [HOLD_W-1:0] hold_i,
    output logic              sel_o
);

    typedef struct packed {
        clk_state_e        state;
        logic [HOLD_W-1:0] cnt;
        logic              sel;
    } clk_regs_t;

    clk_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            CS_TRACK: begin
                if (los_i) begin
                    r_d.state = CS_FREE;
                    r_d.cnt   = '0;
                end
            end
            CS_FREE: begin
                if (los_i) begin
                    r_d.cnt = '0;
                end else if (r_q.cnt >= hold_i) begin
                    r_d.state = CS_TRACK;
                    r_d.cnt   = '0;
                end else if (tick_i) begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: begin
                r_d.state = CS_FREE;
                r_d.cnt   = '0;
            end
        endcase
        r_d.sel = slave_i && (r_d.state == CS_TRACK);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{state: CS_FREE, cnt: '0, sel: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sel_o = r_q.sel;

endmodule

// File: rtl/t1ar_freeze_ctl.sv
module t1ar_freeze_ctl
    import t1ar_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic lfa_i,
    input  logic los_i,
    input  logic sync_i,
    input  logic dis_i,
    output logic freeze_o
);

    typedef struct packed {
        frz_state_e state;
        logic       frz;
    } frz_regs_t;

    frz_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (dis_i) begin
            r_d.state = FZ_IDLE;
        end else if (lfa_i || los_i) begin
            r_d.state = FZ_HOLD;
        end else begin
            unique case (r_q.state)
                FZ_IDLE:  r_d.state = FZ_IDLE;
                FZ_HOLD:  r_d.state = sync_i ? FZ_ARMED : FZ_HOLD;
                FZ_ARMED: begin
                    if (!sync_i) begin
                        r_d.state = FZ_HOLD;
                    end else if (tick_i) begin
                        r_d.state = FZ_IDLE;
                    end
                end
                default:  r_d.state = FZ_IDLE;
            endcase
        end
        r_d.frz = (r_d.state != FZ_IDLE);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{state: FZ_IDLE, frz: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign freeze_o = r_q.frz;

endmodule

// File: rtl/t1_alarm_resp.sv
module t1_alarm_resp #(
    parameter int DW     = 1,
    parameter int HOLD_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              frm_tick_i,
    input  logic              lfa_i,
    input  logic              sync_i,
    input  logic              los_i,
    input  logic              rai_auto_en_i,
    input  logic              ais_transp_i,
    input  logic              slave_mode_i,
    input  logic              freeze_dis_i,
    input  logic [HOLD_W-1:0] los_hold_i,
    input  logic [DW-1:0]     rx_data_i,
    output logic              rai_req_o,
    output logic              ais_active_o,
    output logic [DW-1:0]     rx_sys_data_o,
    output logic              clk_sel_o,
    output logic              freeze_o
);

    t1ar_rai_ctl u_rai (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lfa_i  (lfa_i),
        .sync_i (sync_i),
        .en_i   (rai_auto_en_i),
        .rai_o  (rai_req_o)
    );

    t1ar_ais_path #(.DW(DW)) u_ais (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sync_i   (sync_i),
        .transp_i (ais_transp_i),
        .data_i   (rx_data_i),
        .ais_o    (ais_active_o),
        .data_o   (rx_sys_data_o)
    );

    t1ar_clk_fallback #(.HOLD_W(HOLD_W)) u_clk (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (frm_tick_i),
        .los_i   (los_i),
        .slave_i (slave_mode_i),
        .hold_i  (los_hold_i),
        .sel_o   (clk_sel_o)
    );

    t1ar_freeze_ctl u_frz (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (frm_tick_i),
        .lfa_i    (lfa_i),
        .los_i    (los_i),
        .sync_i   (sync_i),
        .dis_i    (freeze_dis_i),
        .freeze_o (freeze_o)
    );

endmodule

// File: rtl/t1ar_checker.sv
module t1ar_checker #(
    parameter int DW = 1
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          lfa_i,
    input logic          sync_i,
    input logic          los_i,
    input logic          rai_auto_en_i,
    input logic          ais_transp_i,
    input logic          slave_mode_i,
    input logic          freeze_dis_i,
    input logic [DW-1:0] rx_data_i,
    input logic          rai_req_o,
    input logic          ais_active_o,
    input logic [DW-1:0] rx_sys_data_o,
    input logic          clk_sel_o,
    input logic          freeze_o
);

    assert_rai_raise_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rai_auto_en_i && lfa_i |=> rai_req_o);

    assert_rai_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rai_auto_en_i || (sync_i && !lfa_i)) |=> !rai_req_o);

    assert_ais_force_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sync_i && !ais_transp_i |=> ais_active_o && (&rx_sys_data_o));

    assert_transp_pass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ais_transp_i |=> !ais_active_o && rx_sys_data_o == $past(rx_data_i));

    assert_los_fallback_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        los_i |=> !clk_sel_o);

    assert_master_cfg_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !slave_mode_i |=> !clk_sel_o);

    assert_freeze_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !freeze_dis_i && (lfa_i || los_i) |=> freeze_o);

    assert_freeze_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        freeze_o && !sync_i && !freeze_dis_i |=> freeze_o);

    assert_freeze_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        freeze_dis_i |=> !freeze_o);

endmodule

bind t1_alarm_resp t1ar_checker #(.DW(DW)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .lfa_i         (lfa_i),
    .sync_i        (sync_i),
    .los_i         (los_i),
    .rai_auto_en_i (rai_auto_en_i),
    .ais_transp_i  (ais_transp_i),
    .slave_mode_i  (slave_mode_i),
    .freeze_dis_i  (freeze_dis_i),
    .rx_data_i     (rx_data_i),
    .rai_req_o     (rai_req_o),
    .ais_active_o  (ais_active_o),
    .rx_sys_data_o (rx_sys_data_o),
    .clk_sel_o     (clk_sel_o),
    .freeze_o      (freeze_o)
);

// File: tb/sim_t1_alarm_resp.sv
module sim_t1_alarm_resp;

    localparam int DW     = 4;
    localparam int HOLD_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0, lfa = 1'b0, sync = 1'b1, los = 1'b0;
    logic              rai_en = 1'b0, transp = 1'b0, slave = 1'b1, fdis = 1'b0;
    logic [HOLD_W-1:0] hold = 3'd3;
    logic [DW-1:0]     rxd = '0;
    logic              rai, ais, csel, frz;
    logic [DW-1:0]     sysd;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    t1_alarm_resp #(.DW(DW), .HOLD_W(HOLD_W)) u0 (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .frm_tick_i    (tick),
        .lfa_i         (lfa),
        .sync_i        (sync),
        .los_i         (los),
        .rai_auto_en_i (rai_en),
        .ais_transp_i  (transp),
        .slave_mode_i  (slave),
        .freeze_dis_i  (fdis),
        .los_hold_i    (hold),
        .rx_data_i     (rxd),
        .rai_req_o     (rai),
        .ais_active_o  (ais),
        .rx_sys_data_o (sysd),
        .clk_sel_o     (csel),
        .freeze_o      (frz)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Inputs change just after a falling edge; after step() the next rising edge has sampled them.
    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic frame();
        tick = 1'b1;
        step(1);
        tick = 1'b0;
    endtask

    task automatic t_reset();
        step(1);
        chk("R11 rai", rai, 0);
        chk("R11 ais", ais, 0);
        chk("R11 data", sysd, 0);
        chk("R11 clksel", csel, 0);
        chk("R11 freeze", frz, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_rai();
        rai_en = 1'b1; sync = 1'b0; lfa = 1'b1;
        step(1);
        chk("R1 raise on lfa", rai, 1);
        lfa = 1'b0;
        step(2);
        chk("R2 held while async", rai, 1);
        sync = 1'b1;
        step(1);
        chk("R2 withdrawn on sync", rai, 0);
        rai_en = 1'b0; lfa = 1'b1; sync = 1'b0;
        step(2);
        chk("R2 disabled no raise", rai, 0);
        lfa = 1'b0; sync = 1'b1;
        step(1);
    endtask

    task automatic t_ais();
        transp = 1'b0; sync = 1'b0; rxd = 4'h5;
        step(1);
        chk("R3 ais flag", ais, 1);
        chk("R3 all ones", sysd, 15);
        sync = 1'b1; rxd = 4'h6;
        step(1);
        chk("R4 sync pass data", sysd, 6);
        chk("R4 sync ais off", ais, 0);
        transp = 1'b1; sync = 1'b0; rxd = 4'h9;
        step(1);
        chk("R4 transp data", sysd, 9);
        chk("R4 transp ais off", ais, 0);
        rxd = 4'h2;
        step(1);
        chk("R4 transp data2", sysd, 2);
        transp = 1'b0; sync = 1'b1; rxd = '0;
        step(1);
    endtask

    task automatic t_clk();
        slave = 1'b1; los = 1'b1; hold = 3'd3;
        step(1);
        chk("R5 los master", csel, 0);
        los = 1'b0;
        frame(); frame(); frame();
        chk("R6 not early", csel, 0);
        step(1);
        chk("R6 return after hold", csel, 1);
        los = 1'b1;
        step(1);
        chk("R5 fallback again", csel, 0);
        los = 1'b0;
        frame(); frame();
        los = 1'b1;
        step(1);
        los = 1'b0;
        frame(); frame(); frame();
        chk("R6 count restarted", csel, 0);
        step(1);
        chk("R6 return after restart", csel, 1);
        los = 1'b1;
        step(1);
        hold = 3'd0; los = 1'b0;
        step(1);
        chk("R6 zero hold", csel, 1);
        slave = 1'b0;
        step(3);
        chk("R7 master config", csel, 0);
        slave = 1'b1;
        step(1);
        chk("R5 slave tracks", csel, 1);
    endtask

    task automatic t_freeze();
        fdis = 1'b0; sync = 1'b1; lfa = 1'b1;
        step(1);
        chk("R8 freeze on lfa", frz, 1);
        lfa = 1'b0; sync = 1'b0;
        frame(); frame();
        chk("R9 held while async", frz, 1);
        sync = 1'b1; tick = 1'b1;
        step(1);
        tick = 1'b0;
        chk("R9 no release on same tick", frz, 1);
        step(2);
        chk("R9 waits for tick", frz, 1);
        frame();
        chk("R9 released", frz, 0);
        los = 1'b1;
        step(1);
        chk("R8 freeze on los", frz, 1);
        los = 1'b0; fdis = 1'b1;
        step(1);
        chk("R10 disabled clears", frz, 0);
        lfa = 1'b1;
        step(2);
        chk("R10 disabled stays low", frz, 0);
        lfa = 1'b0; fdis = 1'b0;
        step(1);
    endtask

    initial begin
        t_reset();
        t_rai();
        t_ais();
        t_clk();
        t_freeze();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule